// File: doc/BRIEF.md
# Three-Scale Dyadic Wavelet Filterbank

This block turns a stream of signed 12-bit electrogram samples into six subband signals for a downstream event detector. Each accepted sample runs through a cascade of three smoothing stages. Each stage applies the binomial kernel with integer taps 1, 3, 3, 1 to the smoothed signal of the stage before it. The tap spacing doubles from one stage to the next (1, 2 and 4 samples), so the outputs cover scales 2, 4 and 8 without decimation. At every scale the block produces two outputs. The biphasic output is an antisymmetric first difference of the stage input, taken at the stage's tap spacing. The monophasic output is a symmetric signal: the same binomial kernel applied to the stage input, which is also the smoothed signal passed to the next scale. The datapath uses only adders, subtractors and shifts.

Samples arrive with a one-cycle valid pulse, at any rate down to one per clock. All six results are registered together and presented with a one-cycle valid strobe on the clock that follows the accepting edge. No strobe is raised until the history of the widest stage holds real samples. Each internal stage adds enough bits for its gain, so no input sequence can overflow.

Top module: `wavelet_filterbank`

## Requirements
- R1: A synchronous active-high reset clears the priming count, the valid strobe, all six outputs and every history register. After reset the filters behave as if all earlier samples were zero.
- R2: Let a0[n] be the input sample and a(j)[n] the smoothed signal of scale j, with spacing d = 2^(j-1). The biphasic output of scale j (j = 1, 2, 3) equals a(j-1)[n] - a(j-1)[n-d].
- R3: The monophasic output of scale j equals a(j)[n] = a(j-1)[n] + 3·a(j-1)[n-d] + 3·a(j-1)[n-2d] + a(j-1)[n-3d].
- R4: When a sample is accepted on a rising edge and the block is primed, `outValid` is high during the cycle that follows that edge and carries the results for that sample. Back-to-back samples give back-to-back strobes.
- R5: The first 21 samples accepted after reset raise no strobe and leave all outputs at zero. The 22nd sample and every later one raise a strobe.
- R6: In a cycle without `sampleValid`, no history register changes and the outputs keep their last values. Idle gaps between samples therefore do not change any result.
- R7: Output widths are 13, 16 and 19 bits for biphasic scales 1 to 3, and 15, 18 and 21 bits for monophasic scales 1 to 3, all two's complement. Full-scale inputs of -2048 and +2047 give exact results with no wrap.
- R8: A reset in the middle of a stream restarts priming, and later results depend only on samples accepted after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Accept `sampleData` on this edge |
| sampleData | input | 12 | Signed input sample |
| outValid | output | 1 | Six results valid for one cycle |
| biph1 | output | 13 | Biphasic subband, scale 2 |
| biph2 | output | 16 | Biphasic subband, scale 4 |
| biph3 | output | 19 | Biphasic subband, scale 8 |
| mono1 | output | 15 | Monophasic subband, scale 2 |
| mono2 | output | 18 | Monophasic subband, scale 4 |
| mono3 | output | 21 | Monophasic subband, scale 8 |

## Verification
All six results for a sample are due on the clock after the edge that accepted it. The driver records that cycle number with each expected entry, and the monitor, which samples on the falling edge, checks that the strobe shows up in exactly that cycle. During the first 21 samples after a reset no entry is queued, so any strobe in that window has nothing to match and is flagged. In cycles without a strobe the monitor checks that the six outputs have not moved since the last result.

// File: rtl/wfb_pkg.sv
package wfb_pkg;

  // Strobes from the sequencing logic to the arithmetic
  typedef struct packed {
    logic shiftEn;   // push the current sample into every history line
    logic outLoad;   // capture the six subband values
  } wfbStrobe_t;

  // Samples of history needed before the widest stage is fully fed:
  // stage s spans 3*2^s samples, summed over all stages.
  function automatic int primeLen(input int numScales);
    int total;
    total = 0;
    for (int s = 0; s < numScales; s++) total += 3 * (1 << s);
    return total;
  endfunction

  // Accumulator width: each binomial stage has gain 8 (3 bits)
  function automatic int accWidth(input int sampleW, input int numScales);
    return sampleW + 3 * numScales;
  endfunction

endpackage

// File: rtl/wfb_ctrl.sv
module wfb_ctrl
  import wfb_pkg::*;
#(
  parameter int NUM_SCALES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output wfbStrobe_t strobe,
  output logic       outValid
);

  localparam int PRIME = primeLen(NUM_SCALES);
  localparam int CW    = $clog2(PRIME + 1);

  logic [CW-1:0] primeCnt;
  logic          primed;

  assign primed = (primeCnt == CW'(PRIME));

  always_ff @(posedge clk) begin
    if (rst) begin
      primeCnt <= '0;
    end else if (inValid && !primed) begin
      primeCnt <= primeCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.outLoad = inValid && primed;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobe.outLoad;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && primeCnt == '0));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && primed) |=> outValid);

  // R4
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  // R5
  prime_gate_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> primed);

  // R5
  prime_bound_chk: assert property (@(posedge clk) disable iff (rst)
    primeCnt <= CW'(PRIME));

endmodule

// File: rtl/wfb_stage.sv
module wfb_stage #(
  parameter int AW      = 21,
  parameter int SPACING = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shiftEn,
  input  logic signed [AW-1:0] cur,
  output logic signed [AW-1:0] smooth,
  output logic signed [AW-1:0] detail
);

  localparam int HL = 3 * SPACING;

  // hist[k] holds the stage input from k+1 accepted samples ago
  logic [HL-1:0][AW-1:0] hist;
  logic signed [AW-1:0]  tapNear, tapMid, tapFar;

  assign tapNear = $signed(hist[SPACING-1]);
  assign tapMid  = $signed(hist[2*SPACING-1]);
  assign tapFar  = $signed(hist[3*SPACING-1]);

  function automatic logic signed [AW-1:0] times3(input logic signed [AW-1:0] v);
    return (v <<< 1) + v;
  endfunction

  always_comb begin
    smooth = cur + times3(tapNear) + times3(tapMid) + tapFar;
    detail = cur - tapNear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shiftEn) begin
      hist <= {hist[HL-2:0], cur};
    end
  end

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shiftEn |=> $stable(hist));

endmodule

// File: rtl/wfb_datapath.sv
module wfb_datapath
  import wfb_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int NUM_SCALES = 3
) (
  input  logic                                                     clk,
  input  logic                                                     rst,
  input  wfbStrobe_t                                               strobe,
  input  logic signed [SAMPLE_W-1:0]                               sampleIn,
  output logic [NUM_SCALES-1:0][accWidth(SAMPLE_W,NUM_SCALES)-1:0] biphOut,
  output logic [NUM_SCALES-1:0][accWidth(SAMPLE_W,NUM_SCALES)-1:0] monoOut
);

  localparam int AW = accWidth(SAMPLE_W, NUM_SCALES);

  logic signed [AW-1:0] chainV  [NUM_SCALES+1];
  logic signed [AW-1:0] detailV [NUM_SCALES];

  assign chainV[0] = {{(AW-SAMPLE_W){sampleIn[SAMPLE_W-1]}}, sampleIn};

  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_scale
    wfb_stage #(
      .AW     (AW),
      .SPACING(1 << s)
    ) u_stage (
      .clk    (clk),
      .rst    (rst),
      .shiftEn(strobe.shiftEn),
      .cur    (chainV[s]),
      .smooth (chainV[s+1]),
      .detail (detailV[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      biphOut <= '0;
      monoOut <= '0;
    end else if (strobe.outLoad) begin
      for (int s = 0; s < NUM_SCALES; s++) begin
        biphOut[s] <= detailV[s];
        monoOut[s] <= chainV[s+1];
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.outLoad |=> ($stable(biphOut) && $stable(monoOut)));

endmodule

// File: rtl/wavelet_filterbank.sv
module wavelet_filterbank
  import wfb_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  output logic                       outValid,
  output logic signed [SAMPLE_W:0]   biph1,
  output logic signed [SAMPLE_W+3:0] biph2,
  output logic signed [SAMPLE_W+6:0] biph3,
  output logic signed [SAMPLE_W+2:0] mono1,
  output logic signed [SAMPLE_W+5:0] mono2,
  output logic signed [SAMPLE_W+8:0] mono3
);

  localparam int NUM_SCALES = 3;
  localparam int AW         = accWidth(SAMPLE_W, NUM_SCALES);

  wfbStrobe_t                       strobe;
  logic [NUM_SCALES-1:0][AW-1:0]    bFull;
  logic [NUM_SCALES-1:0][AW-1:0]    mFull;

  wfb_ctrl #(
    .NUM_SCALES(NUM_SCALES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (sampleValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  wfb_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .NUM_SCALES(NUM_SCALES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sampleIn(sampleData),
    .biphOut (bFull),
    .monoOut (mFull)
  );

  assign biph1 = bFull[0][SAMPLE_W:0];
  assign biph2 = bFull[1][SAMPLE_W+3:0];
  assign biph3 = bFull[2][SAMPLE_W+6:0];
  assign mono1 = mFull[0][SAMPLE_W+2:0];
  assign mono2 = mFull[1][SAMPLE_W+5:0];
  assign mono3 = mFull[2];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |->
      ((&bFull[0][AW-1:SAMPLE_W])   || !(|bFull[0][AW-1:SAMPLE_W]))   &&
      ((&bFull[1][AW-1:SAMPLE_W+3]) || !(|bFull[1][AW-1:SAMPLE_W+3])) &&
      ((&bFull[2][AW-1:SAMPLE_W+6]) || !(|bFull[2][AW-1:SAMPLE_W+6])) &&
      ((&mFull[0][AW-1:SAMPLE_W+2]) || !(|mFull[0][AW-1:SAMPLE_W+2])) &&
      ((&mFull[1][AW-1:SAMPLE_W+5]) || !(|mFull[1][AW-1:SAMPLE_W+5])));

endmodule

// File: tb/wavelet_filterbank_tb_top.sv
`timescale 1ns/1ps
module wavelet_filterbank_tb_top;

  localparam int PRIME = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic signed [11:0] sampleData = '0;
  logic outValid;
  logic signed [12:0] biph1;
  logic signed [15:0] biph2;
  logic signed [18:0] biph3;
  logic signed [14:0] mono1;
  logic signed [17:0] mono2;
  logic signed [20:0] mono3;

  always #2 clk = ~clk;

  wavelet_filterbank dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
    .outValid(outValid), .biph1(biph1), .biph2(biph2), .biph3(biph3),
    .mono1(mono1), .mono2(mono2), .mono3(mono3)
  );

  typedef struct {
    longint b1, b2, b3, m1, m2, m3;
    int     due;
  } expItem_t;

  expItem_t expQ[$];
  int  xs [512];
  int  idx = 0;
  int  cyc = 0;
  int  nChecks = 0;
  int  nFail = 0;
  int  validSeen = 0;
  bit  finished = 0;
  longint lastB1, lastB2, lastB3, lastM1, lastM2, lastM3;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model straight from R2/R3; samples before index 0 are zero
  function automatic longint refA(input int j, input int n);
    if (n < 0) return 0;
    if (j == 0) return longint'(xs[n]);
    begin
      int d;
      d = 1 << (j - 1);
      return refA(j-1, n) + 3*refA(j-1, n-d) + 3*refA(j-1, n-2*d) + refA(j-1, n-3*d);
    end
  endfunction

  function automatic longint refB(input int j, input int n);
    return refA(j-1, n) - refA(j-1, n - (1 << (j-1)));
  endfunction

  task automatic sendSample(input int v, input int gap);
    expItem_t e;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = 12'(v);
    xs[idx] = v;
    if (idx >= PRIME) begin
      e.b1 = refB(1, idx); e.b2 = refB(2, idx); e.b3 = refB(3, idx);
      e.m1 = refA(1, idx); e.m2 = refA(2, idx); e.m3 = refA(3, idx);
      e.due = cyc + 1;
      expQ.push_back(e);
    end
    idx++;
    repeat (gap) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idx = 0;
    validSeen = 0;
    for (int k = 0; k < 512; k++) xs[k] = 0;
    // R1: everything cleared right after reset
    chk(!outValid, "R1", "outValid after reset", longint'(outValid), 0);
    chk(biph1 == 0 && biph2 == 0 && biph3 == 0 && mono1 == 0 && mono2 == 0 && mono3 == 0,
        "R1", "outputs after reset", longint'(mono3), 0);
    chk(expQ.size() == 0, "R1", "pending results at reset", longint'(expQ.size()), 0);
  endtask

  task automatic primeCheck();
    // R5: 21 samples in, no strobe and outputs still zero
    chk(validSeen == 0, "R5", "strobes during priming", longint'(validSeen), 0);
    chk(biph1 == 0 && biph2 == 0 && biph3 == 0 && mono1 == 0 && mono2 == 0 && mono3 == 0,
        "R5", "outputs during priming", longint'(biph1), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      lastB1 = 0; lastB2 = 0; lastB3 = 0; lastM1 = 0; lastM2 = 0; lastM3 = 0;
    end else if (outValid) begin
      validSeen++;
      if (expQ.size() == 0) begin
        chk(1'b0, "R5", "unexpected outValid", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(cyc == e.due, "R4", "result cycle", longint'(cyc), longint'(e.due));
        chk(longint'(biph1) == e.b1, "R2", "biph1", longint'(biph1), e.b1);
        chk(longint'(biph2) == e.b2, "R2", "biph2", longint'(biph2), e.b2);
        chk(longint'(biph3) == e.b3, "R2", "biph3", longint'(biph3), e.b3);
        chk(longint'(mono1) == e.m1, "R3", "mono1", longint'(mono1), e.m1);
        chk(longint'(mono2) == e.m2, "R3", "mono2", longint'(mono2), e.m2);
        chk(longint'(mono3) == e.m3, "R3", "mono3", longint'(mono3), e.m3);
      end
      lastB1 = biph1; lastB2 = biph2; lastB3 = biph3;
      lastM1 = mono1; lastM2 = mono2; lastM3 = mono3;
    end else begin
      // R6: outputs hold when no result is presented
      chk(longint'(biph1) == lastB1 && longint'(biph2) == lastB2 && longint'(biph3) == lastB3 &&
          longint'(mono1) == lastM1 && longint'(mono2) == lastM2 && longint'(mono3) == lastM3,
          "R6", "hold mono3", longint'(mono3), lastM3);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 512; k++) xs[k] = 0;
    doReset();

    // Priming with zeros, then an impulse with mixed gaps (R2, R3, R5, R6)
    for (int k = 0; k < PRIME; k++) sendSample(0, 1);
    idle(2);
    primeCheck();
    sendSample(1000, 0);
    for (int k = 0; k < 30; k++) sendSample(0, (k % 3 == 0) ? 2 : 0);
    idle(3);

    // Random stream with random gaps (R2, R3, R4, R6)
    for (int k = 0; k < 80; k++) begin
      int v;
      int g;
      v = int'($urandom_range(4095)) - 2048;
      g = int'($urandom_range(2));
      sendSample(v, g);
    end
    idle(3);

    // R7: full-scale alternation then a constant minimum
    for (int k = 0; k < 30; k++) sendSample((k % 2 == 0) ? -2048 : 2047, 0);
    for (int k = 0; k < 30; k++) sendSample(-2048, 0);
    for (int k = 0; k < 20; k++) sendSample(2047, 0);
    idle(4);
    chk(expQ.size() == 0, "R4", "results drained", longint'(expQ.size()), 0);

    // R8: reset mid-stream restarts priming and clears history
    for (int k = 0; k < 5; k++) sendSample(1500, 0);
    idle(3);
    doReset();
    for (int k = 0; k < PRIME; k++) sendSample(int'($urandom_range(4095)) - 2048, 0);
    idle(2);
    primeCheck();
    chk(validSeen == 0, "R8", "no strobe before re-prime", longint'(validSeen), 0);
    for (int k = 0; k < 40; k++) sendSample(int'($urandom_range(4095)) - 2048, k % 2);
    idle(4);
    chk(expQ.size() == 0, "R8", "results drained after re-prime", longint'(expQ.size()), 0);
    chk(validSeen == 40, "R8", "strobe count after re-prime", longint'(validSeen), 40);

    finished = 1;
    summary();
    $finish;
  end

endmodule